// File: doc/BRIEF.md
# Resume-Reset Passthrough with Delayed Release

This block drives the reset line of a chipset's always-on well from a resume-domain power-good input. When the input falls, the reset is asserted on the next clock edge. When the input rises, release is held back by a programmable number of millisecond ticks. The block acts only while the input and the output disagree. Once they agree it leaves the output alone.

A power sequencer reads a separate good status, which is a plain copy of the input level. The sequencer uses it to decide whether it may leave soft-off. The millisecond time base is an external one-cycle tick pulse.

If the input drops while a release is pending, the pending count is dropped. The next rise starts the full delay again.

Top module: `rsm_rst_pass`

## Requirements
- R1: When the input level equals the output level at a clock edge, the output keeps its value across that edge.
- R2: The block keeps an elapsed count. At each edge where the input is high, the output is low and elapsed < delay, a tick adds one to elapsed. The output goes high at the first edge where the input is high and elapsed >= delay. With a tick every cycle, the output therefore reads high delay+1 edges after the input is first sampled high.
- R3: If the input is low at a clock edge while the output is high, the output is low after that edge, without waiting for any tick.
- R4: A low input at any edge clears the elapsed count. A later rise waits the full programmed delay again, and the output stays low during a short input pulse.
- R5: The elapsed count changes only on edges where ms_tick_i is high, except when it is cleared.
- R6: A delay value of zero releases the output at the first edge that samples the input high. The output reads high one cycle after the rise.
- R7: While rst_ni is low, the output is low and the elapsed count is zero.
- R8: good_o equals rsm_pwrok_i at all times, combinationally, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| rsm_pwrok_i | input | 1 | Resume-domain power-good input, synchronous to clk_i |
| rel_dly_i | input | DLY_W | Release delay in ticks |
| rst_rel_o | output | 1 | Chipset resume reset; high means released |
| good_o | output | 1 | Resume-reset good status, a copy of the input |

## Verification
The assertions take two things for granted. The input and the tick are already synchronous to clk_i. The tick is a pulse sampled at clock edges, with no width requirement. The bench applies all stimulus on the falling edge, so every edge samples settled values. It varies the delay only between scenarios, so the release latency it expects follows from the tick pattern alone. Its stimulus covers several tick spacings, a zero delay, an input pulse shorter than the delay, a drop right after release, and a reset applied while the output is released.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int unsigned RSM_DLY_W_DEF = 8;
  typedef enum logic {
    REL_ASSERTED = 1'b0,
    REL_RELEASED = 1'b1
  } rel_state_e;
endpackage

// File: rtl/rsm_dly_cnt.sv
module rsm_dly_cnt #(
  parameter int unsigned DLY_W = rsm_pkg::RSM_DLY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             done_o
);
  logic [DLY_W-1:0] elapsed_q;

  assign done_o = (elapsed_q >= dly_i);

  // count only while armed; saturates at the programmed delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                elapsed_q <= '0;
    else if (!arm_i)            elapsed_q <= '0;
    else if (tick_i && !done_o) elapsed_q <= elapsed_q + 1'b1;
  end

  p_abort_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (elapsed_q == '0));
  p_tick_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !tick_i) |=> $stable(elapsed_q));
endmodule

// File: rtl/rsm_out_reg.sv
module rsm_out_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic done_i,
  output logic rel_o
);
  import rsm_pkg::*;
  rel_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!lvl_i)      st_d = REL_ASSERTED;
    else if (done_i) st_d = REL_RELEASED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= REL_ASSERTED;
    else         st_q <= st_d;
  end

  assign rel_o = (st_q == REL_RELEASED);

  p_agree_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == rel_o) |=> $stable(rel_o));
  p_release_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rel_o && !done_i) |=> !rel_o);
  p_fast_assert_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && rel_o) |=> !rel_o);
endmodule

// File: rtl/rsm_rst_pass.sv
module rsm_rst_pass #(
  parameter int unsigned DLY_W = rsm_pkg::RSM_DLY_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ms_tick_i,
  input  logic             rsm_pwrok_i,
  input  logic [DLY_W-1:0] rel_dly_i,
  output logic             rst_rel_o,
  output logic             good_o
);
  logic arm, done;

  // a pending release exists only while input high and output still low
  assign arm    = rsm_pwrok_i && !rst_rel_o;
  assign good_o = rsm_pwrok_i;

  rsm_dly_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ms_tick_i),
    .arm_i  (arm),
    .dly_i  (rel_dly_i),
    .done_o (done)
  );

  rsm_out_reg u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (rsm_pwrok_i),
    .done_i (done),
    .rel_o  (rst_rel_o)
  );

  p_rise_needs_input_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_rel_o) |-> $past(rsm_pwrok_i));
  p_zero_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsm_pwrok_i && !rst_rel_o && rel_dly_i == '0) |=> rst_rel_o);
endmodule

// File: tb/tb_rsm_rst_pass.sv
module tb_rsm_rst_pass;
  localparam int unsigned DLY_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic pwrok = 1'b0;
  logic [DLY_W-1:0] dly = '0;
  logic rel, good;

  int vectors = 0;
  int miscompares = 0;
  int cyc_no = 0;
  int tick_period = 1;
  bit done_flag = 0;

  // reference model
  int  m_elapsed = 0;
  bit  m_out = 0;

  always #5 clk = ~clk;

  rsm_rst_pass #(.DLY_W(DLY_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .rsm_pwrok_i(pwrok),
    .rel_dly_i(dly), .rst_rel_o(rel), .good_o(good)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_elapsed <= 0;
      m_out     <= 0;
    end else if (!pwrok) begin
      m_elapsed <= 0;
      m_out     <= 0;
    end else if (!m_out) begin
      if (m_elapsed >= int'(dly)) begin
        m_out     <= 1;
        m_elapsed <= 0;
      end else if (tick) begin
        m_elapsed <= m_elapsed + 1;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc_no);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // one clock; tick pattern from tick_period, checks at falling edge
  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) begin
      tick = (tick_period > 0) && (cyc_no % tick_period == 0);
      @(posedge clk);
      @(negedge clk);
      cyc_no++;
      chk({tag, " out"}, rel, m_out);
      chk("R8 good", good, pwrok);
    end
  endtask

  // cycles from input rise to output high, tick every cycle
  task automatic latency(string tag, int d);
    int n = 0;
    dly = d[DLY_W-1:0];
    tick_period = 1;
    pwrok = 1;
    while (!rel && n < 400) begin
      run(tag, 1);
      n++;
    end
    vectors++;
    if (n != d + 1) begin
      miscompares++;
      $display("FAIL %s latency: actual %0d expected %0d", tag, n, d + 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    pwrok = 1;
    #1;
    chk("R7 reset out", rel, 1'b0);
    chk("R8 good in reset", good, 1'b1);
    pwrok = 0;
    #1;
    chk("R8 good low", good, 1'b0);
    rst_n = 1;
    run("R7", 3);

    latency("R2 delay3", 3);
    run("R1 agree high", 5);
    pwrok = 0;
    run("R3 fast assert", 1);
    chk("R3 low after one edge", rel, 1'b0);
    run("R1 agree low", 4);

    latency("R6 zero delay", 0);
    pwrok = 0;
    run("R3", 2);

    // short pulse aborts count
    dly = 6; tick_period = 1;
    pwrok = 1; run("R4 pulse", 3);
    pwrok = 0; run("R4 pulse low", 2);
    chk("R4 held low", rel, 1'b0);
    latency("R4 full delay again", 6);

    // sparse ticks
    pwrok = 0; run("R3", 2);
    dly = 3; tick_period = 4;
    pwrok = 1; run("R5 sparse tick", 20);
    tick_period = 0; pwrok = 0; run("R3", 1);
    pwrok = 1; run("R5 no tick", 10);
    chk("R5 stays low without tick", rel, 1'b0);
    tick_period = 3; run("R5 resumes", 15);

    // drop right after release
    pwrok = 0; run("R3", 2);
    dly = 1; tick_period = 2;
    pwrok = 1; run("R2 sparse", 6);
    pwrok = 0; run("R3 drop", 1);
    pwrok = 1; run("R4 restart", 8);

    // reset while released
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R7 async reset", rel, 1'b0);
    @(negedge clk);
    rst_n = 1;
    run("R7 after reset", 1);
    latency("R2 delay5", 5);

    done_flag = 1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end
endmodule